// File: doc/BRIEF.md
# Endpoint Packet Buffer with Length-Triggered Release

This block is the buffer of one endpoint. It sits between a processor bus and the serial engine of a USB device. For the transmit (IN) direction, the processor fills the buffer through a data port that is either 32 or 16 bits wide. The buffer counts the bytes it accepts. When the count reaches the value in the length register, it hands the packet to the serial engine and no further action is needed. The length register takes its value from the max-packet register whenever that register is written, and again after every release. Software writes a smaller length only for a short final packet. A control bit forces a partial packet out, including an empty one.

For the receive (OUT) direction, the serial engine pushes bytes one at a time. Each acknowledged packet loads the received byte count into the same length/count register. The processor then drains the bytes through the data port.

A bus reset clears the registers in the same way as the system reset.

Top module: `ep_pkt_buf`

## Requirements
- R1: After `rst` or `bus_reset`, the length/count register and the max-packet register read 0, the control register reads 0, and `tx_ready` is 0.
- R2: The register map on `cpu_addr` is: 0 = data port, 1 = length/count, 2 = max-packet, 3 = control. Writing max-packet with value v stores min(v[15:0], BUF_BYTES) in both max-packet and length/count. Both read back that value.
- R3: Writing the length/count register with a value smaller than max-packet makes the current IN packet release after exactly that many bytes.
- R4: In the IN direction, `tx_ready` rises in the cycle after the data write that brings the accepted byte count up to a nonzero length. At that point `tx_len` equals the length. A full-size packet needs no other action.
- R5: In 32-bit mode (`port16`=0), each data write adds min(4, length − count) bytes, taken from the write word starting at bits 7:0 and moving upward. The serial engine receives them in that order.
- R6: In 16-bit mode (`port16`=1), each data write adds min(2, length − count) bytes from bits 7:0 and then bits 15:8. Bits 31:16 are ignored.
- R7: Writing 1 to control bit 0 in the IN direction releases the bytes written so far, with `tx_len` set to that count. With no bytes written, the released packet is empty and `tx_len` is 0.
- R8: After any release, the length/count register reads the max-packet value again.
- R9: While `tx_ready` is 1, data-port writes are discarded. Each `tx_pop` presents the next packet byte on `tx_byte` in the following cycle. `tx_done` clears `tx_ready`, and the next packet starts at byte 0.
- R10: With control bit 1 set (OUT direction), every `rx_we` stores `rx_byte` in order. `rx_ack` loads the length/count register with the number of bytes stored since the previous acknowledge. The count saturates at BUF_BYTES, and extra bytes are dropped.
- R11: In the OUT direction, data-port reads return received bytes in order. A 32-bit read returns 4 bytes, lowest byte in bits 7:0. A 16-bit read returns 2 bytes in bits 15:0, and the upper bits are 0. Positions at or beyond the count read as 0, so an odd final byte appears alone in bits 7:0.
- R12: `cpu_rdata` holds the read result in the cycle after `cpu_rd`. Control reads return the direction in bit 1 and 0 in bit 0. Data-port reads in the IN direction return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset from the serial engine; clears the registers |
| port16 | input | 1 | 1 = 16-bit data port, 0 = 32-bit |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, one cycle after `cpu_rd` |
| tx_ready | output | 1 | An IN packet is released for transmission |
| tx_len | output | 16 | Byte count of the released packet |
| tx_pop | input | 1 | Serial engine takes the next byte |
| tx_byte | output | 8 | Byte requested by the previous `tx_pop` |
| tx_done | input | 1 | Packet sent; frees the buffer |
| rx_we | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_ack | input | 1 | Received packet acknowledged |

## Verification
The assertions assume the following about the inputs. `port16` and the direction bit change only while no IN packet is partly written or pending. The length is not lowered below the number of bytes already accepted. `rx_ack` never arrives in the same cycle as `rx_we`. The stimulus changes mode and direction only between packets. Random lengths are drawn from 1 up to the max-packet value before any byte is written. Receive bytes are pushed first and acknowledged afterwards, and `tx_pop` and `tx_done` are issued only while `tx_ready` is high.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_LEN  = 2'd1,
    REG_MPS  = 2'd2,
    REG_CTRL = 2'd3
  } ep_reg_e;

  localparam int unsigned CTRL_VAL_BIT = 0;
  localparam int unsigned CTRL_DIR_BIT = 1;
  localparam int unsigned LANES        = 4;
endpackage

// File: rtl/ep_lane_ram.sv
module ep_lane_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep_in_path.sv
module ep_in_path #(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 16,
  parameter int AW        = 7
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             port16,
  input  logic             wr_data,
  input  logic [31:0]      wdata,
  input  logic             man_val,
  input  logic [CNT_W-1:0] len,
  input  logic             tx_pop,
  input  logic             tx_done,
  output logic [3:0]       lane_we,
  output logic [31:0]      lane_wdata,
  output logic [AW-1:0]    waddr,
  output logic [AW-1:0]    raddr,
  output logic [1:0]       rd_lane,
  output logic             tx_ready,
  output logic [CNT_W-1:0] tx_len,
  output logic             validated
);
  logic [CNT_W-1:0] cnt_q, room, take, nb, new_cnt, tx_len_q;
  logic [AW+1:0]    rd_ptr_q;
  logic [1:0]       off, rd_lane_q;
  logic             tx_ready_q, accept, auto_val, man_ok;

  always_comb begin
    room     = (len > cnt_q) ? len - cnt_q : '0;
    nb       = port16 ? CNT_W'(2) : CNT_W'(4);
    take     = (room < nb) ? room : nb;
    accept   = wr_data && !tx_ready_q;
    new_cnt  = cnt_q + take;
    auto_val = accept && (len != '0) && (new_cnt == len);
    man_ok   = man_val && !tx_ready_q;
    off      = cnt_q[1:0];
    lane_wdata = wdata << {off, 3'b000};
    for (int k = 0; k < 4; k++) begin
      lane_we[k] = accept && (k >= int'(off)) && ((k - int'(off)) < int'(take));
    end
  end

  assign validated = auto_val || man_ok;
  assign waddr     = cnt_q[AW+1:2];
  assign raddr     = rd_ptr_q[AW+1:2];
  assign rd_lane   = rd_lane_q;
  assign tx_ready  = tx_ready_q;
  assign tx_len    = tx_len_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q      <= '0;
      rd_ptr_q   <= '0;
      rd_lane_q  <= '0;
      tx_ready_q <= 1'b0;
      tx_len_q   <= '0;
    end else begin
      if (validated) begin
        tx_ready_q <= 1'b1;
        tx_len_q   <= auto_val ? new_cnt : cnt_q;
        cnt_q      <= '0;
        rd_ptr_q   <= '0;
      end else if (accept) begin
        cnt_q <= new_cnt;
      end
      if (tx_ready_q && tx_done) begin
        tx_ready_q <= 1'b0;
        rd_ptr_q   <= '0;
      end else if (tx_ready_q && tx_pop) begin
        rd_ptr_q  <= rd_ptr_q + 1'b1;
        rd_lane_q <= rd_ptr_q[1:0];
      end
    end
  end

  // R4
  auto_len_chk: assert property (@(posedge clk) disable iff (clr)
    auto_val |=> tx_ready_q && (tx_len_q == $past(len)));
  // R9
  hold_until_done_chk: assert property (@(posedge clk) disable iff (clr)
    tx_ready_q && !tx_done |=> tx_ready_q);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (clr)
    tx_ready_q && tx_done |=> !tx_ready_q);
  // R6
  half_lanes_chk: assert property (@(posedge clk) disable iff (clr)
    port16 |-> $countones(lane_we) <= 2);
endmodule

// File: rtl/ep_out_path.sv
module ep_out_path #(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 16,
  parameter int AW        = 7
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             port16,
  input  logic             rx_we,
  input  logic [7:0]       rx_byte,
  input  logic             rx_ack,
  input  logic             rd_data,
  input  logic [CNT_W-1:0] count,
  output logic [3:0]       lane_we,
  output logic [31:0]      lane_wdata,
  output logic [AW-1:0]    waddr,
  output logic [AW-1:0]    raddr,
  output logic [CNT_W-1:0] rx_count,
  output logic [3:0]       rd_mask,
  output logic             rd_half
);
  localparam logic [CNT_W-1:0] BUF_CNT = CNT_W'(BUF_BYTES);

  logic [CNT_W-1:0] rx_ptr_q, rd_ptr_q, nb;
  logic [3:0]       mask_d, mask_q;
  logic             room_ok, half_q;

  assign room_ok    = rx_ptr_q < BUF_CNT;
  assign nb         = port16 ? CNT_W'(2) : CNT_W'(4);
  assign lane_wdata = {4{rx_byte}};
  assign waddr      = rx_ptr_q[AW+1:2];
  assign raddr      = rd_ptr_q[AW+1:2];
  assign rx_count   = rx_ptr_q;
  assign rd_mask    = mask_q;
  assign rd_half    = half_q;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_we[k] = rx_we && room_ok && (rx_ptr_q[1:0] == 2'(k));
    assign mask_d[k]  = ({rd_ptr_q[CNT_W-1:2], 2'(k)} < count) &&
                        (!port16 || (rd_ptr_q[1] == 1'(k / 2)));
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rx_ptr_q <= '0;
      rd_ptr_q <= '0;
      mask_q   <= '0;
      half_q   <= 1'b0;
    end else begin
      if (rx_ack) begin
        rx_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (rx_we && room_ok) rx_ptr_q <= rx_ptr_q + 1'b1;
        if (rd_data) rd_ptr_q <= rd_ptr_q + nb;
      end
      if (rd_data) begin
        mask_q <= mask_d;
        half_q <= rd_ptr_q[1];
      end
    end
  end

  // R10
  rx_cap_chk: assert property (@(posedge clk) disable iff (clr)
    rx_ptr_q <= BUF_CNT);
  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (clr)
    rx_ack |=> rx_ptr_q == '0);
  // R11
  mask_half_chk: assert property (@(posedge clk) disable iff (clr)
    rd_data && port16 |=> $countones(rd_mask) <= 2);
endmodule

// File: rtl/ep_pkt_buf.sv
module ep_pkt_buf
  import ep_buf_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_reset,
  input  logic        port16,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic [1:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        tx_ready,
  output logic [15:0] tx_len,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  input  logic        tx_done,
  input  logic        rx_we,
  input  logic [7:0]  rx_byte,
  input  logic        rx_ack
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int AW    = $clog2(WORDS);
  localparam logic [CNT_W-1:0] BUF_CNT = CNT_W'(BUF_BYTES);

  logic       clr;
  ep_reg_e    reg_sel;
  logic       wr_data, wr_len, wr_mps, wr_ctrl;
  logic [CNT_W-1:0] mps_q, len_q, wval;
  logic       dir_q;

  assign clr     = rst | bus_reset;
  assign reg_sel = ep_reg_e'(cpu_addr);
  assign wr_data = cpu_wr && (reg_sel == REG_DATA);
  assign wr_len  = cpu_wr && (reg_sel == REG_LEN);
  assign wr_mps  = cpu_wr && (reg_sel == REG_MPS);
  assign wr_ctrl = cpu_wr && (reg_sel == REG_CTRL);
  assign wval    = (cpu_wdata[CNT_W-1:0] > BUF_CNT) ? BUF_CNT : cpu_wdata[CNT_W-1:0];

  logic [3:0]       in_we, out_we;
  logic [31:0]      in_wd, out_wd;
  logic [AW-1:0]    in_wa, in_ra, out_wa, out_ra;
  logic [1:0]       in_lane;
  logic [CNT_W-1:0] in_tx_len, rx_count;
  logic             in_validated, in_ready;
  logic [3:0]       rd_mask;
  logic             rd_half;

  ep_in_path #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .AW(AW)) u_in (
    .clk(clk), .clr(clr), .port16(port16),
    .wr_data(wr_data && !dir_q), .wdata(cpu_wdata),
    .man_val(wr_ctrl && cpu_wdata[CTRL_VAL_BIT] && !dir_q),
    .len(len_q), .tx_pop(tx_pop), .tx_done(tx_done),
    .lane_we(in_we), .lane_wdata(in_wd), .waddr(in_wa), .raddr(in_ra),
    .rd_lane(in_lane), .tx_ready(in_ready), .tx_len(in_tx_len),
    .validated(in_validated)
  );

  ep_out_path #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .AW(AW)) u_out (
    .clk(clk), .clr(clr), .port16(port16),
    .rx_we(rx_we && dir_q), .rx_byte(rx_byte), .rx_ack(rx_ack && dir_q),
    .rd_data(cpu_rd && (reg_sel == REG_DATA) && dir_q), .count(len_q),
    .lane_we(out_we), .lane_wdata(out_wd), .waddr(out_wa), .raddr(out_ra),
    .rx_count(rx_count), .rd_mask(rd_mask), .rd_half(rd_half)
  );

  logic [31:0]   ram_word;
  logic [AW-1:0] ram_ra;
  assign ram_ra = dir_q ? out_ra : in_ra;

  for (genvar k = 0; k < LANES; k++) begin : g_ram
    ep_lane_ram #(.DEPTH(WORDS), .AW(AW)) u_lane (
      .clk(clk),
      .we(dir_q ? out_we[k] : in_we[k]),
      .waddr(dir_q ? out_wa : in_wa),
      .wdata(dir_q ? out_wd[8*k +: 8] : in_wd[8*k +: 8]),
      .raddr(ram_ra),
      .rdata(ram_word[8*k +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      mps_q <= '0;
      len_q <= '0;
      dir_q <= 1'b0;
    end else begin
      if (wr_mps) begin
        mps_q <= wval;
        len_q <= wval;
      end else if (wr_len) begin
        len_q <= wval;
      end else if (in_validated) begin
        len_q <= mps_q;
      end else if (dir_q && rx_ack) begin
        len_q <= rx_count;
      end
      if (wr_ctrl) dir_q <= cpu_wdata[CTRL_DIR_BIT];
    end
  end

  logic [31:0] rd_reg_q, masked;
  logic        rd_ram_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_reg_q <= '0;
      rd_ram_q <= 1'b0;
    end else begin
      rd_ram_q <= cpu_rd && (reg_sel == REG_DATA) && dir_q;
      if (cpu_rd) begin
        unique case (reg_sel)
          REG_LEN:  rd_reg_q <= 32'(len_q);
          REG_MPS:  rd_reg_q <= 32'(mps_q);
          REG_CTRL: rd_reg_q <= 32'({dir_q, 1'b0});
          default:  rd_reg_q <= '0;
        endcase
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign masked[8*k +: 8] = ram_word[8*k +: 8] & {8{rd_mask[k]}};
  end

  assign cpu_rdata = !rd_ram_q ? rd_reg_q :
                     !port16   ? masked :
                     {16'b0, rd_half ? masked[31:16] : masked[15:0]};
  assign tx_ready  = in_ready;
  assign tx_len    = 16'(in_tx_len);
  assign tx_byte   = ram_word[{in_lane, 3'b000} +: 8];

  // R1
  len_reset_chk: assert property (@(posedge clk)
    clr |=> (len_q == '0) && (mps_q == '0) && !tx_ready);
  // R2
  mps_len_chk: assert property (@(posedge clk) disable iff (clr)
    wr_mps |=> len_q == mps_q);
  // R8
  reload_chk: assert property (@(posedge clk) disable iff (clr)
    in_validated |=> len_q == mps_q);
endmodule

// File: tb/ep_pkt_buf_test.sv
module ep_pkt_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 512;

  logic clk = 0, rst = 1, bus_reset = 0, port16 = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [1:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic tx_ready, tx_pop = 0, tx_done = 0;
  logic [15:0] tx_len;
  logic [7:0] tx_byte, rx_byte = 0;
  logic rx_we = 0, rx_ack = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_b [0:599];

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_pkt_buf uut (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .port16(port16),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .tx_ready(tx_ready), .tx_len(tx_len), .tx_pop(tx_pop),
    .tx_byte(tx_byte), .tx_done(tx_done),
    .rx_we(rx_we), .rx_byte(rx_byte), .rx_ack(rx_ack)
  );

  function automatic int clamp_len(input int v);
    return (v > BUF) ? BUF : v;
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cpu_rd = 1; cpu_addr = a;
    @(negedge clk); cpu_rd = 0; d = cpu_rdata;
  endtask

  task automatic pop_byte(output logic [7:0] b);
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0; b = tx_byte;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_we = 1; rx_byte = b;
    @(negedge clk); rx_we = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); rx_ack = 1;
    @(negedge clk); rx_ack = 0;
  endtask

  // Fill L bytes (max-packet m already set), check release and content
  task automatic in_packet(input int m, input int L, input bit p16, input bit keep);
    int cnt = 0; int nb; logic [31:0] d; logic [7:0] b; logic [31:0] r;
    port16 = p16;
    nb = p16 ? 2 : 4;
    if (L < m) cpu_write(2'd1, 32'(L));
    while (cnt < L) begin
      d = $urandom;
      if (cnt + nb >= L) check(tx_ready == 0, "R4 early", tx_ready, 0);
      cpu_write(2'd0, d);
      for (int j = 0; j < min2(nb, L - cnt); j++) exp_b[cnt + j] = d[8*j +: 8];
      cnt += min2(nb, L - cnt);
    end
    check(tx_ready == 1, (L < m) ? "R3 release" : "R4 release", tx_ready, 1);
    check(int'(tx_len) == L, (L < m) ? "R3 tx_len" : "R4 tx_len", tx_len, L);
    for (int i = 0; i < L; i++) begin
      pop_byte(b);
      check(b == exp_b[i], p16 ? "R6 byte" : "R5 byte", b, exp_b[i]);
    end
    cpu_read(2'd1, r);
    check(int'(r) == m, "R8 reload", r, m);
    if (!keep) pulse_done();
  endtask

  initial begin
    logic [31:0] r; logic [7:0] b; logic [7:0] rb [0:7];
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
    cpu_read(2'd1, r); check(r == 0, "R1 len", r, 0);
    cpu_read(2'd2, r); check(r == 0, "R1 mps", r, 0);
    cpu_read(2'd3, r); check(r == 0, "R12 ctrl", r, 0);
    cpu_read(2'd0, r); check(r == 0, "R12 data in IN dir", r, 0);

    // R2 max-packet load and clamp
    cpu_write(2'd2, 32'd1000);
    cpu_read(2'd1, r); check(int'(r) == clamp_len(1000), "R2 clamp len", r, clamp_len(1000));
    cpu_read(2'd2, r); check(int'(r) == clamp_len(1000), "R2 clamp mps", r, clamp_len(1000));
    cpu_write(2'd2, 32'd8);
    cpu_read(2'd1, r); check(r == 8, "R2 len", r, 8);

    // R4/R5 full packet, 32-bit; then R9 locked write discarded
    in_packet(8, 8, 0, 1);
    cpu_write(2'd0, 32'hDEADBEEF);
    check(tx_len == 8, "R9 locked tx_len", tx_len, 8);
    pulse_done();
    check(tx_ready == 0, "R9 done", tx_ready, 0);
    in_packet(8, 8, 0, 0);   // content check proves the locked write left no trace

    // R3 short packet with partial final word
    in_packet(8, 5, 0, 0);
    // R6 16-bit full and short
    in_packet(8, 8, 1, 0);
    in_packet(8, 5, 1, 0);
    port16 = 0;

    // R7 manual validate of a partial packet
    cpu_write(2'd0, 32'h44332211);
    cpu_write(2'd3, 32'd1);
    check(tx_ready == 1, "R7 manual", tx_ready, 1);
    check(tx_len == 4, "R7 manual len", tx_len, 4);
    pop_byte(b); check(b == 8'h11, "R7 byte0", b, 8'h11);
    pop_byte(b); check(b == 8'h22, "R7 byte1", b, 8'h22);
    cpu_read(2'd1, r); check(r == 8, "R8 after manual", r, 8);
    pulse_done();
    // R7 zero-length packet
    cpu_write(2'd3, 32'd1);
    check(tx_ready == 1, "R7 empty", tx_ready, 1);
    check(tx_len == 0, "R7 empty len", tx_len, 0);
    pulse_done();

    // constrained random IN packets
    for (int p = 0; p < 24; p++) begin
      int m; int L; bit p16;
      m = 1 + ($urandom % 64);
      L = ($urandom % 2) ? 1 + ($urandom % m) : m;
      p16 = 1'($urandom % 2);
      cpu_write(2'd2, 32'(m));
      in_packet(m, L, p16, 0);
    end
    port16 = 0;

    // R10/R11 OUT direction, 32-bit
    cpu_write(2'd3, 32'd2);
    cpu_read(2'd3, r); check(r == 2, "R12 ctrl dir", r, 2);
    for (int i = 0; i < 7; i++) begin rb[i] = 8'($urandom); push_rx(rb[i]); end
    pulse_ack();
    cpu_read(2'd1, r); check(r == 7, "R10 count", r, 7);
    cpu_read(2'd0, r);
    check(r == {rb[3], rb[2], rb[1], rb[0]}, "R11 word0", r, {rb[3], rb[2], rb[1], rb[0]});
    cpu_read(2'd0, r);
    check(r == {8'h00, rb[6], rb[5], rb[4]}, "R11 word1 tail", r, {8'h00, rb[6], rb[5], rb[4]});

    // R11 16-bit, odd count
    port16 = 1;
    for (int i = 0; i < 5; i++) begin rb[i] = 8'($urandom); push_rx(rb[i]); end
    pulse_ack();
    cpu_read(2'd1, r); check(r == 5, "R10 count2", r, 5);
    cpu_read(2'd0, r); check(r == {16'h0, rb[1], rb[0]}, "R11 half0", r, {16'h0, rb[1], rb[0]});
    cpu_read(2'd0, r); check(r == {16'h0, rb[3], rb[2]}, "R11 half1", r, {16'h0, rb[3], rb[2]});
    cpu_read(2'd0, r); check(r == {24'h0, rb[4]}, "R11 odd last", r, {24'h0, rb[4]});
    port16 = 0;

    // R10 saturation
    for (int i = 0; i < BUF + 3; i++) push_rx(8'(i));
    pulse_ack();
    cpu_read(2'd1, r); check(int'(r) == BUF, "R10 saturate", r, BUF);

    // R1 bus reset
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    cpu_read(2'd1, r); check(r == 0, "R1 bus reset len", r, 0);
    cpu_read(2'd3, r); check(r == 0, "R1 bus reset ctrl", r, 0);
    check(tx_ready == 0, "R1 bus reset tx_ready", tx_ready, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule